// File: doc/BRIEF.md
# Ethernet MAC Power-Up Configuration Sequencer

This block is a run-once bus master that brings a triple-speed Ethernet MAC into service after reset. When reset is released it walks a fixed script of register accesses over a memory-mapped port with waitrequest flow control. The script quiets both MAC data paths and pulses the MAC's software reset. It waits for that reset to self-clear, then sets a jumbo-capable maximum frame length and the transmit inter-frame gap, and turns both paths back on.

A compile-time mode selects the PHY link type. With the serial gigabit link the script stops after the paths are re-enabled. With the reduced gigabit parallel link, one more write switches on receive/transmit clock-to-data timing control through the PHY management register window. Every offset, data word and bit position is a parameter. Once the script ends the block raises `done`, drops `busy` and makes no further access until the next reset.

Top module: `macinit_seq`

## Requirements
- R1: The script runs once per reset. While `done` is high, `av_write` and `av_read` stay low until the next reset.
- R2: The writes come in this order. First, offset CMD_OFS takes CFG_BASE with bits TXEN_BIT and RXEN_BIT cleared. Second, CMD_OFS takes that same word with bit RST_BIT set. After the poll of R3, FRMLEN_OFS takes FRMLEN_VAL, then IPG_OFS takes IPG_VAL. Last, CMD_OFS takes CFG_BASE with bits TXEN_BIT and RXEN_BIT set.
- R3: After the software-reset write, the block reads CMD_OFS again and again. It continues to the frame-length write only after a read returns bit RST_BIT as 0. All other read-data bits are ignored.
- R4: With PHY_MODE = PHY_RGMII (value 1), one more write after the enable write puts PHYTIM_VAL at PHYTIM_OFS. With PHY_MODE = PHY_SGMII (value 0), the enable write is the last access.
- R5: `av_write`, `av_address` and `av_writedata` hold steady while `av_waitrequest` is high. A write completes at the rising edge where `av_write` is high and `av_waitrequest` is low.
- R6: `av_read` and `av_address` hold steady while `av_waitrequest` is high. A read completes, and `av_readdata` is taken, at the edge where `av_read` is high and `av_waitrequest` is low.
- R7: `done` stays low until the last access has completed. It then rises and stays high until reset. `busy` is the inverse of `done` at all times.
- R8: While `rst` is high, `av_write`, `av_read` and `done` are low. `av_write` and `av_read` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| av_address | output | ADDR_W | Word address of the MAC register |
| av_write | output | 1 | Write strobe |
| av_writedata | output | DATA_W | Write data |
| av_read | output | 1 | Read strobe |
| av_readdata | input | DATA_W | Read data, valid when the read completes |
| av_waitrequest | input | 1 | Slave stall; the access is held while high |
| done | output | 1 | Configuration script finished (sticky) |
| busy | output | 1 | Script in progress or not yet finished |

## Verification
Four bus rules are checked on every cycle:
- Strobes, address and write data are held through waitrequest stalls.
- Read and write are never asserted together.
- `done` never drops once it is set.
- The bus stays silent after completion.

Only the bench's scenarios can show that the script itself is right. That covers the order of the accesses, the exact offsets and data words, the repeated poll until the reset bit reads back clear, and the extra PHY timing write in one link mode but not the other. For this the bench runs an instance in each mode against a slave model with pseudo-random stalls. It then re-runs both instances after a second reset.

// File: rtl/macinit_pkg.sv
package macinit_pkg;

    typedef enum logic {
        PHY_SGMII = 1'b0,
        PHY_RGMII = 1'b1
    } phy_mode_e;

    typedef enum logic {
        ACC_WRITE = 1'b0,
        ACC_READ  = 1'b1
    } acc_kind_e;

    typedef enum logic [2:0] {
        STEP_QUIESCE   = 3'd0,
        STEP_SOFTRST   = 3'd1,
        STEP_POLLRST   = 3'd2,
        STEP_FRAMELEN  = 3'd3,
        STEP_GAP       = 3'd4,
        STEP_ENABLE    = 3'd5,
        STEP_PHYTIMING = 3'd6,
        STEP_END       = 3'd7
    } step_e;

    typedef enum logic [1:0] {
        PH_LAUNCH = 2'd0,
        PH_WAIT   = 2'd1,
        PH_DONE   = 2'd2
    } phase_e;

    // Successor of a step once its access has completed (poll repeat handled by caller)
    function automatic step_e next_step(input step_e cur, input phy_mode_e mode);
        case (cur)
            STEP_QUIESCE:  return STEP_SOFTRST;
            STEP_SOFTRST:  return STEP_POLLRST;
            STEP_POLLRST:  return STEP_FRAMELEN;
            STEP_FRAMELEN: return STEP_GAP;
            STEP_GAP:      return STEP_ENABLE;
            STEP_ENABLE:   return (mode == PHY_RGMII) ? STEP_PHYTIMING : STEP_END;
            default:       return STEP_END;
        endcase
    endfunction

endpackage

// File: rtl/macinit_step_rom.sv
module macinit_step_rom
    import macinit_pkg::*;
#(
    parameter int unsigned            ADDR_W     = 8,
    parameter int unsigned            DATA_W     = 32,
    parameter logic [ADDR_W-1:0]      CMD_OFS    = 'h02,
    parameter logic [ADDR_W-1:0]      FRMLEN_OFS = 'h05,
    parameter logic [ADDR_W-1:0]      IPG_OFS    = 'h17,
    parameter logic [ADDR_W-1:0]      PHYTIM_OFS = 'h90,
    parameter logic [DATA_W-1:0]      CFG_BASE   = 'h0000_043B,
    parameter int unsigned            TXEN_BIT   = 0,
    parameter int unsigned            RXEN_BIT   = 1,
    parameter int unsigned            RST_BIT    = 13,
    parameter logic [DATA_W-1:0]      FRMLEN_VAL = 'd9600,
    parameter logic [DATA_W-1:0]      IPG_VAL    = 'd12,
    parameter logic [DATA_W-1:0]      PHYTIM_VAL = 'h0000_0082
) (
    input  step_e               step,
    output acc_kind_e           kind,
    output logic [ADDR_W-1:0]   addr,
    output logic [DATA_W-1:0]   data
);

    localparam logic [DATA_W-1:0] PATH_MASK = (DATA_W'(1) << TXEN_BIT) | (DATA_W'(1) << RXEN_BIT);
    localparam logic [DATA_W-1:0] RST_MASK  = DATA_W'(1) << RST_BIT;
    localparam logic [DATA_W-1:0] CFG_OFF   = CFG_BASE & ~PATH_MASK;
    localparam logic [DATA_W-1:0] CFG_RST   = CFG_OFF | RST_MASK;
    localparam logic [DATA_W-1:0] CFG_ON    = CFG_BASE | PATH_MASK;

    always_comb begin
        kind = ACC_WRITE;
        addr = CMD_OFS;
        data = CFG_OFF;
        case (step)
            STEP_QUIESCE: begin
                data = CFG_OFF;
            end
            STEP_SOFTRST: begin
                data = CFG_RST;
            end
            STEP_POLLRST: begin
                kind = ACC_READ;
                data = '0;
            end
            STEP_FRAMELEN: begin
                addr = FRMLEN_OFS;
                data = FRMLEN_VAL;
            end
            STEP_GAP: begin
                addr = IPG_OFS;
                data = IPG_VAL;
            end
            STEP_ENABLE: begin
                data = CFG_ON;
            end
            STEP_PHYTIMING: begin
                addr = PHYTIM_OFS;
                data = PHYTIM_VAL;
            end
            default: begin
                data = CFG_OFF;
            end
        endcase
    end

endmodule

// File: rtl/macinit_bus_master.sv
module macinit_bus_master
    import macinit_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned TEST_BIT = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  acc_kind_e           go_kind,
    input  logic [ADDR_W-1:0]   go_addr,
    input  logic [DATA_W-1:0]   go_data,
    input  logic                av_waitrequest,
    input  logic [DATA_W-1:0]   av_readdata,
    output logic                av_write,
    output logic                av_read,
    output logic [ADDR_W-1:0]   av_address,
    output logic [DATA_W-1:0]   av_writedata,
    output logic                ack,
    output logic                ack_bit
);

    localparam logic [DATA_W-1:0] TEST_MASK = DATA_W'(1) << TEST_BIT;

    logic accept;
    assign accept = (av_write || av_read) && !av_waitrequest;

    always_ff @(posedge clk) begin
        if (rst) begin
            av_write     <= 1'b0;
            av_read      <= 1'b0;
            av_address   <= '0;
            av_writedata <= '0;
            ack          <= 1'b0;
            ack_bit      <= 1'b0;
        end else begin
            ack <= 1'b0;
            if (go) begin
                av_write     <= (go_kind == ACC_WRITE);
                av_read      <= (go_kind == ACC_READ);
                av_address   <= go_addr;
                av_writedata <= go_data;
            end else if (accept) begin
                av_write <= 1'b0;
                av_read  <= 1'b0;
                ack      <= 1'b1;
                ack_bit  <= av_read && |(av_readdata & TEST_MASK);
            end
        end
    end

endmodule

// File: rtl/macinit_seq.sv
module macinit_seq
    import macinit_pkg::*;
#(
    parameter int unsigned            ADDR_W     = 8,
    parameter int unsigned            DATA_W     = 32,
    parameter phy_mode_e              PHY_MODE   = PHY_RGMII,
    parameter logic [ADDR_W-1:0]      CMD_OFS    = 'h02,
    parameter logic [ADDR_W-1:0]      FRMLEN_OFS = 'h05,
    parameter logic [ADDR_W-1:0]      IPG_OFS    = 'h17,
    parameter logic [ADDR_W-1:0]      PHYTIM_OFS = 'h90,
    parameter logic [DATA_W-1:0]      CFG_BASE   = 'h0000_043B,
    parameter int unsigned            TXEN_BIT   = 0,
    parameter int unsigned            RXEN_BIT   = 1,
    parameter int unsigned            RST_BIT    = 13,
    parameter logic [DATA_W-1:0]      FRMLEN_VAL = 'd9600,
    parameter logic [DATA_W-1:0]      IPG_VAL    = 'd12,
    parameter logic [DATA_W-1:0]      PHYTIM_VAL = 'h0000_0082
) (
    input  logic                clk,
    input  logic                rst,
    output logic [ADDR_W-1:0]   av_address,
    output logic                av_write,
    output logic [DATA_W-1:0]   av_writedata,
    output logic                av_read,
    input  logic [DATA_W-1:0]   av_readdata,
    input  logic                av_waitrequest,
    output logic                done,
    output logic                busy
);

    phase_e              phase_q;
    step_e               step_q;
    logic                done_q;
    acc_kind_e           cur_kind;
    logic [ADDR_W-1:0]   cur_addr;
    logic [DATA_W-1:0]   cur_data;
    logic                go;
    logic                ack;
    logic                ack_bit;
    step_e               step_nxt;

    assign go       = (phase_q == PH_LAUNCH);
    assign step_nxt = next_step(step_q, PHY_MODE);

    macinit_step_rom #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CMD_OFS    (CMD_OFS),
        .FRMLEN_OFS (FRMLEN_OFS),
        .IPG_OFS    (IPG_OFS),
        .PHYTIM_OFS (PHYTIM_OFS),
        .CFG_BASE   (CFG_BASE),
        .TXEN_BIT   (TXEN_BIT),
        .RXEN_BIT   (RXEN_BIT),
        .RST_BIT    (RST_BIT),
        .FRMLEN_VAL (FRMLEN_VAL),
        .IPG_VAL    (IPG_VAL),
        .PHYTIM_VAL (PHYTIM_VAL)
    ) u_rom (
        .step (step_q),
        .kind (cur_kind),
        .addr (cur_addr),
        .data (cur_data)
    );

    macinit_bus_master #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .TEST_BIT (RST_BIT)
    ) u_bus (
        .clk            (clk),
        .rst            (rst),
        .go             (go),
        .go_kind        (cur_kind),
        .go_addr        (cur_addr),
        .go_data        (cur_data),
        .av_waitrequest (av_waitrequest),
        .av_readdata    (av_readdata),
        .av_write       (av_write),
        .av_read        (av_read),
        .av_address     (av_address),
        .av_writedata   (av_writedata),
        .ack            (ack),
        .ack_bit        (ack_bit)
    );

    // Phase machine: launch one access, wait for its completion, pick the next step
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_LAUNCH;
            step_q  <= STEP_QUIESCE;
            done_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_LAUNCH: phase_q <= PH_WAIT;
                PH_WAIT: begin
                    if (ack) begin
                        if (step_q == STEP_POLLRST && ack_bit) begin
                            phase_q <= PH_LAUNCH;           // reset bit still set: poll again
                        end else if (step_nxt == STEP_END) begin
                            phase_q <= PH_DONE;
                            done_q  <= 1'b1;
                        end else begin
                            step_q  <= step_nxt;
                            phase_q <= PH_LAUNCH;
                        end
                    end
                end
                default: phase_q <= PH_DONE;
            endcase
        end
    end

    assign done = done_q;
    assign busy = !done_q;

endmodule

// File: rtl/macinit_seq_chk.sv
module macinit_seq_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   av_address,
    input logic                av_write,
    input logic [DATA_W-1:0]   av_writedata,
    input logic                av_read,
    input logic                av_waitrequest,
    input logic                done
);

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (av_write && av_waitrequest) |=> (av_write && $stable(av_address) && $stable(av_writedata))); // R5

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (av_read && av_waitrequest) |=> (av_read && $stable(av_address))); // R6

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(av_write && av_read)); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> done); // R7

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!av_write && !av_read)); // R1

endmodule

bind macinit_seq macinit_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .av_address     (av_address),
    .av_write       (av_write),
    .av_writedata   (av_writedata),
    .av_read        (av_read),
    .av_waitrequest (av_waitrequest),
    .done           (done)
);

// File: tb/macinit_seq_tb.sv
`timescale 1ns/1ps

module macinit_seq_tb_slave #(
    parameter logic [7:0] SEED     = 8'h5A,
    parameter int         POLLS_HI = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic        rd,
    output logic        waitreq,
    output logic [31:0] rdata
);
    logic [7:0] lfsr;
    int         rdcnt;

    always @(posedge clk) begin
        if (rst) begin
            lfsr  <= SEED;
            rdcnt <= 0;
        end else begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (rd && !waitreq) rdcnt <= rdcnt + 1;
        end
    end

    assign waitreq = lfsr[0];
    // unrelated bits set to show they are ignored; bit 13 is the reset flag
    assign rdata = 32'h00F0_0438 | ((rdcnt < POLLS_HI) ? 32'h0000_2000 : 32'h0);
endmodule

module macinit_seq_tb;
    import macinit_pkg::*;

    localparam int POLLS_HI = 3;

    typedef struct packed {
        logic [1:0]  tag;     // 0:R2 1:R3 2:R4
        logic        rd;
        logic [7:0]  a;
        logic [31:0] d;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        wr [2];
    logic        rd [2];
    logic        wq [2];
    logic        done [2];
    logic        busy [2];
    logic [7:0]  ad [2];
    logic [31:0] wd [2];
    logic [31:0] rdt [2];

    item_t exp0 [$];
    item_t exp1 [$];

    int n_cmp = 0;
    int n_bad = 0;

    // index 0: parallel-link mode, index 1: serial-link mode
    macinit_seq #(.PHY_MODE(PHY_RGMII)) u_dut (
        .clk(clk), .rst(rst), .av_address(ad[0]), .av_write(wr[0]), .av_writedata(wd[0]),
        .av_read(rd[0]), .av_readdata(rdt[0]), .av_waitrequest(wq[0]), .done(done[0]), .busy(busy[0]));
    macinit_seq #(.PHY_MODE(PHY_SGMII)) u_dut_sg (
        .clk(clk), .rst(rst), .av_address(ad[1]), .av_write(wr[1]), .av_writedata(wd[1]),
        .av_read(rd[1]), .av_readdata(rdt[1]), .av_waitrequest(wq[1]), .done(done[1]), .busy(busy[1]));

    macinit_seq_tb_slave #(.SEED(8'h5A), .POLLS_HI(POLLS_HI)) u_sl0 (
        .clk(clk), .rst(rst), .wr(wr[0]), .rd(rd[0]), .waitreq(wq[0]), .rdata(rdt[0]));
    macinit_seq_tb_slave #(.SEED(8'hC3), .POLLS_HI(POLLS_HI)) u_sl1 (
        .clk(clk), .rst(rst), .wr(wr[1]), .rd(rd[1]), .waitreq(wq[1]), .rdata(rdt[1]));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push_one(input int k, input item_t it);
        if (k == 0) exp0.push_back(it); else exp1.push_back(it);
    endtask

    // Driver: expected script built from the requirements
    task automatic push_seq(input int k);
        push_one(k, '{tag:2'd0, rd:1'b0, a:8'h02, d:32'h0000_0438});
        push_one(k, '{tag:2'd0, rd:1'b0, a:8'h02, d:32'h0000_2438});
        for (int i = 0; i <= POLLS_HI; i++)
            push_one(k, '{tag:2'd1, rd:1'b1, a:8'h02, d:32'h0});
        push_one(k, '{tag:2'd0, rd:1'b0, a:8'h05, d:32'd9600});
        push_one(k, '{tag:2'd0, rd:1'b0, a:8'h17, d:32'd12});
        push_one(k, '{tag:2'd0, rd:1'b0, a:8'h02, d:32'h0000_043B});
        if (k == 0)
            push_one(k, '{tag:2'd2, rd:1'b0, a:8'h90, d:32'h0000_0082});
    endtask

    // Monitor state
    logic        pw [2];
    logic        pr [2];
    logic [7:0]  pa [2];
    logic [31:0] pd [2];
    logic        pdn [2];

    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin : mon
            item_t it;
            string rq;
            int    qs;
            if (rst) begin
                pw[k] = 1'b0; pr[k] = 1'b0; pdn[k] = 1'b0;
            end else begin
                if (wr[k] && rd[k]) check(1'b0, "R8", "dual strobe", 64'd1, 64'd0);
                if (pw[k])
                    check(wr[k] && ad[k] == pa[k] && wd[k] == pd[k], "R5", "write held in stall",
                          {31'd0, wr[k], ad[k], wd[k]}, {31'd0, 1'b1, pa[k], pd[k]});
                if (pr[k])
                    check(rd[k] && ad[k] == pa[k], "R6", "read held in stall",
                          {55'd0, rd[k], ad[k]}, {55'd0, 1'b1, pa[k]});
                if (pdn[k])
                    check(done[k], "R7", "done sticky", {63'd0, done[k]}, 64'd1);
                check(busy[k] == !done[k], "R7", "busy inverse of done",
                      {63'd0, busy[k]}, {63'd0, !done[k]});
                qs = (k == 0) ? exp0.size() : exp1.size();
                if (qs != 0)
                    check(!done[k], "R7", "done before script end", {63'd0, done[k]}, 64'd0);
                if ((wr[k] || rd[k]) && !wq[k]) begin
                    if (qs == 0) begin
                        check(1'b0, "R1", "unexpected access", {55'd0, rd[k], ad[k]}, 64'd0);
                    end else begin
                        it = (k == 0) ? exp0.pop_front() : exp1.pop_front();
                        rq = (it.tag == 2'd0) ? "R2" : (it.tag == 2'd1) ? "R3" : "R4";
                        check(rd[k] == it.rd && ad[k] == it.a && (it.rd || wd[k] == it.d), rq,
                              (k == 0) ? "access rgmii" : "access sgmii",
                              {23'd0, rd[k], ad[k], wd[k]},
                              {23'd0, it.rd, it.a, it.rd ? wd[k] : it.d});
                    end
                end
                pw[k] = wr[k] && wq[k];
                pr[k] = rd[k] && wq[k];
                pa[k] = ad[k];
                pd[k] = wd[k];
                pdn[k] = done[k];
            end
        end
    end

    task automatic run_once();
        int cnt;
        rst = 1'b1;
        exp0.delete();
        exp1.delete();
        repeat (4) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            check(!wr[k] && !rd[k] && !done[k], "R8", "quiet in reset",
                  {61'd0, wr[k], rd[k], done[k]}, 64'd0);
            check(busy[k], "R7", "busy in reset", {63'd0, busy[k]}, 64'd1);
        end
        push_seq(0);
        push_seq(1);
        rst = 1'b0;
        cnt = 0;
        while (!(done[0] && done[1]) && cnt < 5000) begin
            @(negedge clk);
            cnt++;
        end
        if (cnt >= 5000) check(1'b0, "R7", "watchdog, done never rose", 64'd0, 64'd1);
        repeat (40) begin
            @(negedge clk);
            for (int k = 0; k < 2; k++)
                check(!wr[k] && !rd[k], "R1", "bus idle after done",
                      {62'd0, wr[k], rd[k]}, 64'd0);
        end
        check(exp0.size() == 0, "R4", "rgmii script complete", 64'(exp0.size()), 64'd0);
        check(exp1.size() == 0, "R4", "sgmii script complete", 64'(exp1.size()), 64'd0);
    endtask

    initial begin
        run_once();
        run_once();   // R1: a new reset runs the script again
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL R7 watchdog expired: actual=0 expected=1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule